// File: doc/BRIEF.md
# Serial Memory Slave Command Front-End

This block is the serial-side front end of a memory slave on an SPI bus. A fast system clock oversamples the bus. The bus lines are the serial clock, an active-low select and the serial data input. The block drives a serial data output together with a separate output-enable, which the pad ring turns into a tristate driver.

When the select line falls, the block records whether the bus is using SPI mode 0 or mode 3, based on the level of the serial clock at that moment. It then shifts in an opcode, most significant bit first, and checks it against a fixed set of four commands. The block carries out the status-register part of those commands itself. Every accepted opcode and every data byte is passed to the back end as a single-cycle strobe.

An opcode outside the set locks the interface for the rest of the transaction. The lock clears only when the select line is released and asserted again.

Top module: `spi_fe_top`

## Requirements
- R1: While reset is held, and directly after it, the block shows the following: output-enable low, serial output low, both strobes low, mode flag low, status equal to the STATUS_RST parameter (default 0x00).
- R2: On each falling edge of the select line, the mode flag takes the serial clock level: low selects mode 0 (flag 0), high selects mode 3 (flag 1). The flag holds until the next select.
- R3: Input bits are taken on rising serial-clock edges only, most significant bit first. In mode 3 the high level already present at select is not an edge. Eight rising edges complete a byte.
- R4: A completed opcode of 0x06, 0x04, 0x05 or 0x01 raises cmd_valid for exactly one clock, with cmd_code holding the opcode.
- R5: Any other opcode gives no strobe. All later input is then ignored until the next select: no strobes, no status change, output-enable low.
- R6: Releasing the select line discards a partial byte. The next transaction decodes from its first bit.
- R7: Status bit 1 is the write-latch bit. Opcode 0x06 sets it and opcode 0x04 clears it, in the same cycle as the command strobe.
- R8: After opcode 0x05, each falling serial-clock edge drives the next status bit, starting with bit 7. Output-enable is high from the first such edge. The byte repeats for as long as the clock runs with select low.
- R9: Output-enable is low while the select line is high, and during any transaction that is not a status read.
- R10: After opcode 0x01, the next byte raises data_valid for one clock, with the byte on data_byte. If bit 1 was set, status then takes that byte's bits 7..2 and 0, and bit 1 is cleared. If bit 1 was clear, status is unchanged. Later bytes in the same transaction are ignored.
- R11: Bytes that follow 0x06 or 0x04 in the same transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low slave select |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output, low when not enabled |
| so_oe | output | 1 | Output-enable for the tristate driver on so |
| mode3 | output | 1 | Mode detected at last select: 1 for mode 3, 0 for mode 0 |
| cmd_valid | output | 1 | One-cycle strobe for an accepted opcode |
| cmd_code | output | 8 | Last accepted opcode |
| data_valid | output | 1 | One-cycle strobe for the byte following a status write |
| data_byte | output | 8 | Byte that followed a status write |
| status | output | 8 | Status register contents |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a status reset value of zero, and the write-latch bit at position 1. It drives the serial clock with a half period of six system clocks, which leaves room for the synchronizer and edge-detector latency. That spacing lets a clock-by-clock reference model track every strobe, every status change and every output bit in both bus modes. The scenarios cover the write latch gating a status write, a lockout in the middle of a transaction, and a partial byte dropped on deselect.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WR_ENABLE  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WR_DISABLE = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_READ  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WRITE = 8'h01;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_STAT_RD,
    ST_STAT_WR,
    ST_DONE,
    ST_LOCK
  } fe_state_e;

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    return (op == OP_WR_ENABLE) || (op == OP_WR_DISABLE) ||
           (op == OP_STAT_READ) || (op == OP_STAT_WRITE);
  endfunction
endpackage

// File: rtl/spi_fe_rst_sync.sv
module spi_fe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_en,
  input  logic         sdi,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-2:0]  sr_q, sr_d;

  assign word = {sr_q, sdi};
  assign done = bit_en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (clr) begin
      cnt_d = '0;
      sr_d  = '0;
    end else if (bit_en) begin
      cnt_d = done ? '0 : cnt_q + CW'(1);
      sr_d  = word[W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic [W-1:0] word,
  output logic         sdo,
  output logic         oe
);
  localparam int            CW  = $clog2(W);
  localparam logic [CW-1:0] TOP = CW'(W - 1);

  logic [CW-1:0] idx_q, idx_d;
  logic          sdo_q, sdo_d, oe_q, oe_d;

  always_comb begin
    idx_d = idx_q;
    sdo_d = sdo_q;
    oe_d  = oe_q;
    if (clr) begin
      idx_d = TOP;
      sdo_d = 1'b0;
      oe_d  = 1'b0;
    end else if (shift_en) begin
      sdo_d = word[idx_q];
      oe_d  = 1'b1;
      idx_d = (idx_q == '0) ? TOP : idx_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= TOP;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo = sdo_q & oe_q;
  assign oe  = oe_q;
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  STATUS_RST  = 8'h00,
  parameter int          WEL_BIT     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  output logic       mode3,
  output logic       cmd_valid,
  output logic [7:0] cmd_code,
  output logic       data_valid,
  output logic [7:0] data_byte,
  output logic [7:0] status
);
  logic rst_l;
  logic cs_s, sck_s, si_s;
  logic sck_d, cs_d;

  spi_fe_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_l)
  );

  spi_fe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) bus_sync_i (
    .clk(clk), .rst_n(rst_l), .d({cs_n, sck, si}), .q({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, sel_fall;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign sel_fall = cs_d & ~cs_s;

  fe_state_e         state_q, state_d;
  logic              rx_done;
  logic [BYTE_W-1:0] rx_word;
  logic              rx_en;

  assign rx_en = ~cs_s & sck_rise & ((state_q == ST_OPC) || (state_q == ST_STAT_WR));

  spi_fe_rx #(.W(BYTE_W)) rx_i (
    .clk(clk), .rst_n(rst_l), .clr(cs_s), .bit_en(rx_en), .sdi(si_s),
    .done(rx_done), .word(rx_word)
  );

  logic tx_clr, tx_shift;
  assign tx_clr   = cs_s | (state_q != ST_STAT_RD);
  assign tx_shift = sck_fall;

  logic [7:0] stat_q, stat_d;

  spi_fe_tx #(.W(BYTE_W)) tx_i (
    .clk(clk), .rst_n(rst_l), .clr(tx_clr), .shift_en(tx_shift), .word(stat_q),
    .sdo(so), .oe(so_oe)
  );

  logic       mode_q, mode_d;
  logic       cmdv_q, cmdv_d, datv_q, datv_d;
  logic [7:0] cmdc_q, cmdc_d, datb_q, datb_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cmdv_d  = 1'b0;
    cmdc_d  = cmdc_q;
    datv_d  = 1'b0;
    datb_d  = datb_q;
    stat_d  = stat_q;
    if (sel_fall) mode_d = sck_s;
    if (cs_s) begin
      state_d = ST_OPC;
    end else if (rx_done) begin
      unique case (state_q)
        ST_OPC: begin
          if (op_known(rx_word)) begin
            cmdv_d = 1'b1;
            cmdc_d = rx_word;
            if (rx_word == OP_STAT_READ)       state_d = ST_STAT_RD;
            else if (rx_word == OP_STAT_WRITE) state_d = ST_STAT_WR;
            else begin
              state_d         = ST_DONE;
              stat_d[WEL_BIT] = (rx_word == OP_WR_ENABLE);
            end
          end else begin
            state_d = ST_LOCK;
          end
        end
        ST_STAT_WR: begin
          datv_d  = 1'b1;
          datb_d  = rx_word;
          state_d = ST_DONE;
          if (stat_q[WEL_BIT]) begin
            stat_d          = rx_word;
            stat_d[WEL_BIT] = 1'b0;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_OPC;
      mode_q  <= 1'b0;
      cmdv_q  <= 1'b0;
      cmdc_q  <= '0;
      datv_q  <= 1'b0;
      datb_q  <= '0;
      stat_q  <= STATUS_RST;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cmdv_q  <= cmdv_d;
      cmdc_q  <= cmdc_d;
      datv_q  <= datv_d;
      datb_q  <= datb_d;
      stat_q  <= stat_d;
    end
  end

  assign mode3      = mode_q;
  assign cmd_valid  = cmdv_q;
  assign cmd_code   = cmdc_q;
  assign data_valid = datv_q;
  assign data_byte  = datb_q;
  assign status     = stat_q;
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int WEL_BIT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       data_valid,
  input logic [7:0] status
);
  logic [7:0] last_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_cmd_q <= '0;
    else if (cmd_valid) last_cmd_q <= cmd_code;
  end

  // R9: a select held high for several clocks leaves the output undriven
  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  // R4: command strobe lasts a single cycle
  a_r4_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R10: data strobe lasts a single cycle
  a_r10_data_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R4: command and data strobes never coincide
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, data_valid}));

  // R8: output is enabled only after a status-read opcode
  a_r8_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (last_cmd_q == 8'h05));

  // R7: write-latch bit rises only with a write-enable strobe
  a_r7_latch_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[WEL_BIT]) |-> (cmd_valid && cmd_code == 8'h06));

  // R10: status changes only alongside a strobe
  a_r10_status_changes_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> (cmd_valid || data_valid));
endmodule

bind spi_fe_top spi_fe_chk #(.WEL_BIT(WEL_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .data_valid(data_valid), .status(status)
);

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;
  logic clk, rst_n, sck, cs_n, si;
  logic so, so_oe, mode3, cmd_valid, data_valid;
  logic [7:0] cmd_code, data_byte, status;

  spi_fe_top dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .mode3(mode3), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .data_valid(data_valid), .data_byte(data_byte), .status(status)
  );

  localparam int HALF = 6;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // states: 0 opcode, 1 read, 2 write-status, 3 done, 4 locked
  int         m_rcnt;
  logic       p_sck1, p_sck2, p_sckd, p_cs1, p_cs2, p_csd, p_si1, p_si2;
  int         m_state, m_cnt, m_idx;
  logic [7:0] m_sr, m_stat, m_cc, m_db;
  logic       m_mode, m_cv, m_dv, m_oe, m_so;

  task automatic model_reset();
    p_sck1 = 0; p_sck2 = 0; p_sckd = 0; p_cs1 = 1; p_cs2 = 1; p_csd = 1; p_si1 = 0; p_si2 = 0;
    m_state = 0; m_cnt = 0; m_idx = 7; m_sr = 0; m_stat = 8'h00; m_cc = 0; m_db = 0;
    m_mode = 0; m_cv = 0; m_dv = 0; m_oe = 0; m_so = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0;
      model_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      model_reset();
    end else begin
      logic rise, fall, self, nb;
      logic [7:0] byt;
      rise = p_sck2 & ~p_sckd;
      fall = ~p_sck2 & p_sckd;
      self = p_csd & ~p_cs2;
      m_cv = 0;
      m_dv = 0;
      if (self) m_mode = p_sck2;
      // output side uses the state before this edge
      if (p_cs2 || m_state != 1) begin
        m_oe = 0; m_so = 0; m_idx = 7;
      end else if (fall) begin
        m_so = m_stat[m_idx]; m_oe = 1;
        m_idx = (m_idx == 0) ? 7 : m_idx - 1;
      end
      if (p_cs2) begin
        m_state = 0; m_cnt = 0; m_sr = 0;
      end else if (rise && (m_state == 0 || m_state == 2)) begin
        nb  = p_si2;
        byt = {m_sr[6:0], nb};
        m_sr = byt;
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0;
          m_sr = 0;
          if (m_state == 0) begin
            if (byt == 8'h06 || byt == 8'h04 || byt == 8'h05 || byt == 8'h01) begin
              m_cv = 1; m_cc = byt;
              if (byt == 8'h05) m_state = 1;
              else if (byt == 8'h01) m_state = 2;
              else begin m_state = 3; m_stat[1] = (byt == 8'h06); end
            end else m_state = 4;
          end else begin
            m_dv = 1; m_db = byt; m_state = 3;
            if (m_stat[1]) m_stat = {byt[7:2], 1'b0, byt[0]};
          end
        end
      end
      p_sckd = p_sck2; p_csd = p_cs2;
      p_sck2 = p_sck1; p_cs2 = p_cs1; p_si2 = p_si1;
      p_sck1 = sck;    p_cs1 = cs_n;  p_si1 = si;
    end
  end

  // ---------------- clock-by-clock comparison ----------------
  logic       seen_oe;
  logic [7:0] last_cmd;
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(so_oe == m_oe, "R9 so_oe", so_oe, m_oe);
      chk(so == (m_oe ? m_so : 1'b0), "R8 so", so, m_so);
      chk(cmd_valid == m_cv, "R4 cmd_valid", cmd_valid, m_cv);
      if (m_cv) chk(cmd_code == m_cc, "R4 cmd_code", cmd_code, m_cc);
      chk(data_valid == m_dv, "R10 data_valid", data_valid, m_dv);
      if (m_dv) chk(data_byte == m_db, "R10 data_byte", data_byte, m_db);
      chk(mode3 == m_mode, "R2 mode3", mode3, m_mode);
      chk(status == m_stat, "R7 status", status, m_stat);
      if (so_oe) seen_oe = 1;
      if (cmd_valid) last_cmd = cmd_code;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000 && !done_flag) begin
      done_flag = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- bus master tasks ----------------
  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(input bit m3);
    sck = m3; wclk(HALF);
    cs_n = 0; wclk(HALF);
  endtask

  task automatic deselect(input bit m3);
    if (!m3) sck = 0;
    wclk(HALF);
    cs_n = 1; wclk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] dout, input int nbits, output logic [7:0] din);
    din = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 0; si = dout[i]; wclk(HALF);
      din[i] = so;
      sck = 1; wclk(HALF);
    end
  endtask

  logic [7:0] rd;

  initial begin
    rst_n = 0; sck = 0; cs_n = 1; si = 0;
    seen_oe = 0; last_cmd = 0;
    wclk(5);
    // R1: outputs during reset
    chk(so_oe == 0 && so == 0 && cmd_valid == 0 && data_valid == 0, "R1 strobes in reset",
        {so_oe, so, cmd_valid, data_valid}, 0);
    chk(status == 8'h00 && mode3 == 0, "R1 status/mode in reset", {mode3, status}, 0);
    rst_n = 1; wclk(6);
    chk(status == 8'h00 && so_oe == 0, "R1 after release", {so_oe, status}, 0);

    // R8 R2: mode 0 status read, two repeats of 0x00
    select(0);
    chk(mode3 == 0, "R2 mode0 detect", mode3, 0);
    xfer(8'h05, 8, rd);
    xfer(8'h00, 8, rd); chk(rd == 8'h00, "R8 read byte1", rd, 8'h00);
    chk(so_oe == 1, "R8 oe driven", so_oe, 1);
    xfer(8'h00, 8, rd); chk(rd == 8'h00, "R8 read byte2", rd, 8'h00);
    deselect(0);
    chk(so_oe == 0, "R9 oe off after deselect", so_oe, 0);

    // R3 R7 R2: write enable in mode 3
    select(1);
    chk(mode3 == 1, "R2 mode3 detect", mode3, 1);
    xfer(8'h06, 8, rd);
    chk(last_cmd == 8'h06, "R3 mode3 opcode decode", last_cmd, 8'h06);
    deselect(1);
    chk(status[1] == 1, "R7 latch set", status, 8'h02);

    // R8: read in mode 0 repeats 0x02
    select(0);
    xfer(8'h05, 8, rd);
    xfer(8'h00, 8, rd); chk(rd == 8'h02, "R8 read latch byte1", rd, 8'h02);
    xfer(8'h00, 8, rd); chk(rd == 8'h02, "R8 read latch byte2", rd, 8'h02);
    deselect(0);

    // R10: status write with latch set, second byte ignored
    select(1);
    xfer(8'h01, 8, rd);
    xfer(8'hF3, 8, rd);
    xfer(8'h00, 8, rd);
    deselect(1);
    chk(status == 8'hF1, "R10 status write", status, 8'hF1);

    // R10: status write with latch clear has no effect
    select(0);
    xfer(8'h01, 8, rd);
    xfer(8'h0C, 8, rd);
    deselect(0);
    chk(status == 8'hF1, "R10 write blocked", status, 8'hF1);

    // R5: invalid opcode locks out a following write enable and read
    seen_oe = 0;
    select(0);
    xfer(8'h9F, 8, rd);
    xfer(8'h06, 8, rd);
    xfer(8'h05, 8, rd);
    xfer(8'h00, 8, rd);
    deselect(0);
    chk(status == 8'hF1, "R5 lockout status", status, 8'hF1);
    chk(seen_oe == 0, "R5 lockout oe", seen_oe, 0);

    // R6: partial byte dropped on deselect
    select(1);
    xfer(8'hFF, 4, rd);
    deselect(1);
    select(1);
    xfer(8'h06, 8, rd);
    deselect(1);
    chk(status == 8'hF3, "R6 partial discarded", status, 8'hF3);

    // R11 R9: bytes after write enable ignored, no output
    seen_oe = 0;
    select(0);
    xfer(8'h06, 8, rd);
    xfer(8'h04, 8, rd);
    deselect(0);
    chk(status[1] == 1, "R11 trailing byte ignored", status, 8'hF3);
    chk(seen_oe == 0, "R9 no drive on non-read", seen_oe, 0);

    // R7: write disable clears latch
    select(1);
    xfer(8'h04, 8, rd);
    deselect(1);
    chk(status == 8'hF1, "R7 latch cleared", status, 8'hF1);

    // R8: mode 3 read of 0xF1 twice
    select(1);
    xfer(8'h05, 8, rd);
    xfer(8'h00, 8, rd); chk(rd == 8'hF1, "R8 mode3 read byte1", rd, 8'hF1);
    xfer(8'h00, 8, rd); chk(rd == 8'hF1, "R8 mode3 read byte2", rd, 8'hF1);
    deselect(1);

    wclk(4);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule